// File: doc/BRIEF.md
# Masked GPIO Port Register Bank

This block holds the control and data registers for a set of general-purpose I/O ports, each up to 16 pins wide. Every port has a direction register, an output data register, write-only bit-set and bit-clear registers, a mask register and a pin-level register. Software reaches them through a small memory-mapped bus. The bus carries a byte address, four byte enables and 32-bit data, so byte, half-word and word accesses all work.

The pin-level register is the masked view of a port. A read returns the synchronized level of every pin, whatever its direction, with masked positions forced to zero. A write loads the output register in one access, but only at unmasked positions. The mask itself can be written as two separate bytes or as one half-word at the same base. Each port's block of registers sits 0x20 bytes above the previous port's block.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset, every direction, output and mask register is zero, so `pin_oe` and `pin_out` are all zero and `bus_rvalid` is low.
- R2: `bus_ready` is always high. A read accepted in cycle N returns its data on `bus_rdata` with `bus_rvalid` high in cycle N+1. `bus_rvalid` is low in every cycle that does not follow an accepted read.
- R3: Each bit of `pin_oe` equals the matching direction-register bit, where 1 means output. Each bit of `pin_out` equals the matching output-register bit.
- R4: A write to SET (offset 0x08) ORs the enabled data ones into the output register. A write to CLR (offset 0x0C) clears the enabled data ones. Zero data bits change nothing. The mask does not gate SET or CLR. Both registers read as 0.
- R5: A read of PIN (offset 0x14) returns each pin's level after a two-flop synchronizer, with every bit whose mask bit is 1 read as 0. The direction of the pin does not matter. A pin change made before edge E appears in a read accepted at edge E+2 and not earlier.
- R6: A write to PIN loads the output register only at bit positions whose mask bit is 0 and whose byte is enabled. Every other output bit keeps its value.
- R7: The mask lives at offset 0x10. A byte access at 0x10 (byte enable 0001) covers pins 0–7. A byte access at 0x11 (byte enable 0010) covers pins 8–15. A half-word access at 0x10 (byte enable 0011) covers pins 0–15. The mask reads back as written.
- R8: Port p's registers start at byte address p*0x20. Within a port, DIR is at 0x00, OUT at 0x04, SET at 0x08, CLR at 0x0C, MASK at 0x10 and PIN at 0x14. A write to one port leaves every other port's registers unchanged.
- R9: Only the enabled bytes of DIR, OUT and MASK are written. Data bits 31:16 read as 0. An address beyond the last port, or at word offset 0x18 or 0x1C, reads as 0, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| pin_in | input | NUM_PORTS*PORT_W (80) | Pin levels from pads |
| pin_out | output | NUM_PORTS*PORT_W (80) | Output register values |
| pin_oe | output | NUM_PORTS*PORT_W (80) | Output enables (1 = drive) |

## Verification
The bench builds the block with its default values: five ports, 16 pins per port and an 8-bit address. With these values, addresses 0xA0 to 0xFF decode to port numbers 5 to 7, which do not exist, so out-of-range reads and writes can be exercised directly. A 16-bit port inside a 32-bit data word makes the upper data half reachable, so the bench checks that those bits read as zero. It also checks that the pins-8–15 mask byte is written only when the second byte enable is set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_W      = 32;
    localparam int BE_W       = BUS_W / 8;
    localparam int PORT_SHIFT = 5;   // 0x20 bytes per port
    localparam int WORD_LSB   = 2;
    localparam int WORD_W     = PORT_SHIFT - WORD_LSB;

    typedef enum logic [2:0] {
        RS_DIR  = 3'd0,
        RS_OUT  = 3'd1,
        RS_SET  = 3'd2,
        RS_CLR  = 3'd3,
        RS_MASK = 3'd4,
        RS_PIN  = 3'd5,
        RS_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic             dir;
        logic             out;
        logic             set;
        logic             clr;
        logic             mask;
        logic             pin;
        logic [BE_W-1:0]  be;
        logic [BUS_W-1:0] data;
    } port_wr_t;

    function automatic reg_sel_e word_to_sel(input logic [WORD_W-1:0] w);
        case (w)
            3'd0:    return RS_DIR;
            3'd1:    return RS_OUT;
            3'd2:    return RS_SET;
            3'd3:    return RS_CLR;
            3'd4:    return RS_MASK;
            3'd5:    return RS_PIN;
            default: return RS_NONE;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] be_to_bits(input logic [BE_W-1:0] be);
        logic [BUS_W-1:0] r;
        for (int i = 0; i < BE_W; i++) r[i*8 +: 8] = {8{be[i]}};
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int ADDR_W    = 8,
    localparam int PF_W     = ADDR_W - PORT_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PF_W-1:0]   port_idx,
    output reg_sel_e          sel,
    output logic              hit
);
    logic [1:0] unused_lsb;
    assign unused_lsb = addr[WORD_LSB-1:0];

    assign port_idx = addr[ADDR_W-1:PORT_SHIFT];
    assign sel      = word_to_sel(addr[PORT_SHIFT-1:WORD_LSB]);
    assign hit      = (32'(port_idx) < NUM_PORTS) && (sel != RS_NONE);
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_bank_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  port_wr_t          wr,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] mask_q
);
    logic [BUS_W-1:0]  bm_full;
    logic [PORT_W-1:0] bm, wd, open_bits;
    logic [PORT_W-1:0] dir_d, out_d, mask_d;
    logic              unused_hi;
    logic              any_wr;

    assign bm_full   = be_to_bits(wr.be);
    assign bm        = bm_full[PORT_W-1:0];
    assign wd        = wr.data[PORT_W-1:0];
    assign unused_hi = ^{wr.data, bm_full};
    assign open_bits = bm & ~mask_q;
    assign any_wr    = wr.dir | wr.out | wr.set | wr.clr | wr.mask | wr.pin;

    always_comb begin
        dir_d  = wr.dir  ? ((dir_q  & ~bm) | (wd & bm)) : dir_q;
        mask_d = wr.mask ? ((mask_q & ~bm) | (wd & bm)) : mask_q;
        // masked load first, then direct and set/clear updates on top
        out_d = out_q;
        if (wr.pin) out_d = (out_d & ~open_bits) | (wd & open_bits);
        if (wr.out) out_d = (out_d & ~bm) | (wd & bm);
        if (wr.set) out_d = out_d | (wd & bm);
        if (wr.clr) out_d = out_d & ~(wd & bm);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            out_q  <= '0;
            mask_q <= '0;
        end else begin
            dir_q  <= dir_d;
            out_q  <= out_d;
            mask_q <= mask_d;
        end
    end

    AST_MASKED_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr.pin && !wr.out && !wr.set && !wr.clr) |=> (((out_q ^ $past(out_q)) & $past(mask_q)) == '0)); // R6
    AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (rst)
        (wr.set && !wr.clr && !wr.pin && !wr.out) |=> (($past(out_q) & ~out_q) == '0)); // R4
    AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (rst)
        (wr.clr && !wr.set && !wr.pin && !wr.out) |=> ((out_q & ~$past(out_q)) == '0)); // R4
    AST_IDLE_PORT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !any_wr |=> ($stable(out_q) && $stable(dir_q) && $stable(mask_q))); // R8
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 16,
    parameter int ADDR_W    = 8,
    localparam int PF_W     = ADDR_W - PORT_SHIFT,
    localparam int PINS     = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic              bus_rvalid,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    logic [PF_W-1:0]   dec_idx;
    reg_sel_e          dec_sel;
    logic              dec_hit;
    logic [PINS-1:0]   pin_s;
    logic [PORT_W-1:0] dir_a  [NUM_PORTS];
    logic [PORT_W-1:0] out_a  [NUM_PORTS];
    logic [PORT_W-1:0] mask_a [NUM_PORTS];
    logic [BUS_W-1:0]  rd_val;
    logic [PORT_W-1:0] rd_mask;
    logic              wr_go, rd_go, rd_is_pin;

    assign bus_ready = 1'b1;
    assign wr_go     = bus_valid && bus_write && dec_hit;
    assign rd_go     = bus_valid && !bus_write;
    assign rd_is_pin = rd_go && dec_hit && (dec_sel == RS_PIN);

    gpio_bus_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .port_idx(dec_idx), .sel(dec_sel), .hit(dec_hit)
    );

    gpio_sync2 #(.W(PINS)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_wr_t pw;
        logic     sel_me;
        assign sel_me  = wr_go && (dec_idx == PF_W'(p));
        assign pw.dir  = sel_me && (dec_sel == RS_DIR);
        assign pw.out  = sel_me && (dec_sel == RS_OUT);
        assign pw.set  = sel_me && (dec_sel == RS_SET);
        assign pw.clr  = sel_me && (dec_sel == RS_CLR);
        assign pw.mask = sel_me && (dec_sel == RS_MASK);
        assign pw.pin  = sel_me && (dec_sel == RS_PIN);
        assign pw.be   = bus_be;
        assign pw.data = bus_wdata;

        gpio_port_regs #(.PORT_W(PORT_W)) u_regs (
            .clk(clk), .rst(rst), .wr(pw),
            .dir_q(dir_a[p]), .out_q(out_a[p]), .mask_q(mask_a[p])
        );

        assign pin_out[p*PORT_W +: PORT_W] = out_a[p];
        assign pin_oe [p*PORT_W +: PORT_W] = dir_a[p];
    end

    always_comb begin
        rd_val  = '0;
        rd_mask = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (dec_idx == PF_W'(p)) begin
                rd_mask = mask_a[p];
                case (dec_sel)
                    RS_DIR:  rd_val = BUS_W'(dir_a[p]);
                    RS_OUT:  rd_val = BUS_W'(out_a[p]);
                    RS_MASK: rd_val = BUS_W'(mask_a[p]);
                    RS_PIN:  rd_val = BUS_W'(pin_s[p*PORT_W +: PORT_W] & ~mask_a[p]);
                    default: rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_go;
            if (rd_go) bus_rdata <= dec_hit ? rd_val : '0;
        end
    end

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> bus_rvalid); // R2
    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> !bus_rvalid); // R2
    AST_PIN_READ_MASKED: assert property (@(posedge clk) disable iff (rst)
        rd_is_pin |=> ((bus_rdata[PORT_W-1:0] & $past(rd_mask)) == '0)); // R5
    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_go && !dec_hit) |=> (bus_rdata == '0)); // R9
endmodule

// File: tb/sim_gpio_mask_bank.sv
`timescale 1ns/1ps
module sim_gpio_mask_bank;
    localparam int NP = 5;
    localparam int PW = 16;
    localparam int AW = 8;
    localparam int NPIN = NP * PW;

    logic            clk = 0;
    logic            rst = 1;
    logic            bus_valid = 0, bus_write = 0;
    logic            bus_ready, bus_rvalid;
    logic [AW-1:0]   bus_addr = '0;
    logic [3:0]      bus_be = '0;
    logic [31:0]     bus_wdata = '0, bus_rdata;
    logic [NPIN-1:0] pin_in = '0, pin_out, pin_oe;

    always #5 clk = ~clk;

    gpio_mask_bank #(.NUM_PORTS(NP), .PORT_W(PW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    int n_vec = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] m_dir[NP], m_out[NP], m_mask[NP];

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: read responses
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) chk(1'b0, "R2 unexpected rvalid", 128'(bus_rdata), 0);
            else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(bus_rdata === e, t, 128'(bus_rdata), 128'(e));
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        int p; int w; logic [15:0] bm; logic [15:0] dd; logic [15:0] op;
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk);
        #1 bus_valid = 0; bus_write = 0;
        p = int'(a[7:5]); w = int'(a[4:2]);
        bm = {{8{be[1]}}, {8{be[0]}}}; dd = d[15:0];
        if (p < NP) begin
            case (w)
                0: m_dir[p]  = (m_dir[p] & ~bm) | (dd & bm);
                1: m_out[p]  = (m_out[p] & ~bm) | (dd & bm);
                2: m_out[p]  = m_out[p] | (dd & bm);
                3: m_out[p]  = m_out[p] & ~(dd & bm);
                4: m_mask[p] = (m_mask[p] & ~bm) | (dd & bm);
                5: begin op = bm & ~m_mask[p]; m_out[p] = (m_out[p] & ~op) | (dd & op); end
                default: ;
            endcase
        end
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [3:0] be, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_be = be;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk);
        #1 bus_valid = 0;
    endtask

    task automatic check_ports(input string req);
        logic [NPIN-1:0] eo, ed;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            eo[p*PW +: PW] = m_out[p];
            ed[p*PW +: PW] = m_dir[p];
        end
        chk(pin_out === eo, {req, " pin_out"}, 128'(pin_out), 128'(eo));
        chk(pin_oe === ed, {req, " pin_oe"}, 128'(pin_oe), 128'(ed));
    endtask

    bit done = 0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin m_dir[p] = 0; m_out[p] = 0; m_mask[p] = 0; end
        pin_in[2*PW +: PW] = 16'h1234;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        @(negedge clk);
        chk(bus_rvalid === 1'b0, "R1 rvalid after reset", 128'(bus_rvalid), 0);
        chk(bus_ready === 1'b1, "R2 ready high", 128'(bus_ready), 1);
        check_ports("R1 reset");
        bus_rd(8'h10, 4'b0011, 32'h0, "R1 mask port0 reset");
        bus_rd(8'h80, 4'b1111, 32'h0, "R1 dir port4 reset");

        // R3 direction and output drive
        bus_wr(8'h20, 4'b1111, 32'h0000_00FF);
        bus_wr(8'h24, 4'b1111, 32'h0000_A5A5);
        check_ports("R3 dir/out port1");
        bus_rd(8'h24, 4'b1111, 32'h0000_A5A5, "R3 out readback");

        // R4 set/clear, not gated by mask
        bus_wr(8'h28, 4'b1111, 32'h0000_000F);
        check_ports("R4 set");
        bus_wr(8'h2C, 4'b1111, 32'h0000_A000);
        check_ports("R4 clr");
        bus_wr(8'h30, 4'b0011, 32'h0000_FFFF);
        bus_wr(8'h28, 4'b0011, 32'h0000_3000);
        bus_wr(8'h2C, 4'b0011, 32'h0000_0001);
        check_ports("R4 set/clr with full mask");
        bus_rd(8'h24, 4'b1111, 32'h0000_35AE, "R4 out value");
        bus_rd(8'h28, 4'b1111, 32'h0, "R4 set reads zero");

        // R7 mask byte and half-word aliases on port2
        bus_wr(8'h50, 4'b0011, 32'h0000_0F0F);
        bus_wr(8'h51, 4'b0010, 32'h0000_FF00);
        bus_rd(8'h50, 4'b0011, 32'h0000_FF0F, "R7 byte1 write");
        bus_wr(8'h50, 4'b0001, 32'h0000_0000);
        bus_rd(8'h50, 4'b0011, 32'h0000_FF00, "R7 byte0 write");

        // R5 masked pin read and two-clock latency
        bus_rd(8'h54, 4'b0011, 32'h0000_0034, "R5 masked pin read");
        pin_in[2*PW +: PW] = 16'hFFFF;
        bus_rd(8'h54, 4'b0011, 32'h0000_0034, "R5 latency edge1");
        bus_rd(8'h54, 4'b0011, 32'h0000_0034, "R5 latency edge2");
        bus_rd(8'h54, 4'b0011, 32'h0000_00FF, "R5 latency edge3");

        // R5 direction does not matter: port1 has mixed direction
        pin_in[1*PW +: PW] = 16'hC3C3;
        bus_wr(8'h30, 4'b0011, 32'h0);
        repeat (3) @(posedge clk);
        bus_rd(8'h34, 4'b1111, 32'h0000_C3C3, "R5 pin read mixed dir");

        // R6 masked pin write
        bus_wr(8'h54, 4'b0011, 32'h0000_ABCD);
        check_ports("R6 masked pin write");
        bus_wr(8'h50, 4'b0011, 32'h0);
        bus_wr(8'h54, 4'b0010, 32'h0000_1200);
        check_ports("R6 byte pin write");
        bus_rd(8'h44, 4'b1111, 32'h0000_12CD, "R6 out port2");

        // R8 port spacing and isolation
        bus_wr(8'h84, 4'b1111, 32'h0000_8001);
        check_ports("R8 port4 only");
        bus_rd(8'h84, 4'b1111, 32'h0000_8001, "R8 port4 out");
        bus_rd(8'h64, 4'b1111, 32'h0, "R8 port3 untouched");

        // R9 byte enables, upper bits, unmapped
        bus_wr(8'h60, 4'b1111, 32'hFFFF_FFFF);
        bus_rd(8'h60, 4'b1111, 32'h0000_FFFF, "R9 upper half zero");
        bus_wr(8'h60, 4'b0001, 32'h0);
        bus_rd(8'h60, 4'b1111, 32'h0000_FF00, "R9 byte enable dir");
        bus_rd(8'h18, 4'b1111, 32'h0, "R9 offset 0x18 reads zero");
        bus_rd(8'hA0, 4'b1111, 32'h0, "R9 port5 reads zero");
        bus_wr(8'hA4, 4'b1111, 32'h0000_FFFF);
        bus_wr(8'h1C, 4'b1111, 32'h0000_FFFF);
        check_ports("R9 unmapped writes ignored");

        repeat (4) @(posedge clk);
        chk(exp_q.size() == 0, "R2 all reads answered", 128'(exp_q.size()), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule